// File: doc/BRIEF.md
# Banked Cartridge ROM Bank-Select Latch

This block holds the bank-switching state of a banked game cartridge for an 8-bit home computer. The host CPU picks a bank by writing a small number anywhere in the I/O page that the cartridge decodes. The write is seen as the active-low I/O-page select together with a high Phi2 phase and an active-low write strobe. The block registers the low bits of the data bus and places them on the ROM address lines above the 8 KiB window offset. As a result, each bank value exposes one 8 KiB block of a ROM much larger than the host can map at once.

The host's thirteen low address lines go straight to the ROM. The two active-low window strobes, low-ROM and high-ROM, are combined into a single active-low ROM enable. The ROM size is a parameter, and it sets how many bank bits are kept. A second build variant treats each bank as a 16 KiB pair. In that variant the low-ROM strobe picks the half, so the register value moves up one address line.

Top module: `cart_bank_latch`

## Requirements
- R1: While reset is asserted, and on leaving reset, the bank register is 0, so the ROM address lines above the window offset are all 0.
- R2: On a rising clock edge where ioSelN=0, phi2=1 and rwN=0, the register loads from the data bus. From then on, romAddr carries the new value starting at address bit 13, with data bit 0 on ROM A13 and each higher data bit on the next address line.
- R3: On an edge where phi2=0 or ioSelN=1, the register keeps its value.
- R4: A read cycle (rwN=1) leaves the register unchanged even when ioSelN=0 and phi2=1.
- R5: Only data bits below BANK_W are kept, where BANK_W = log2(ROM_KB/8) minus WINDOW_A13 (4 for 128 KiB, 5 for 256 KiB, 6 for 512 KiB). Data bit 7 and any other higher bits have no effect.
- R6: romAddr[12:0] always equals hostAddrLo[12:0], combinationally.
- R7: romEnN equals romLowN AND romHighN, combinationally.
- R8: With WINDOW_A13=1, romAddr[13] follows romLowN and the bank value occupies romAddr from bit 14 upward.
- R9: When a qualifying write is held across several clocks with the same data, the bank outputs hold that value without changing between edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the bank register |
| rstN | input | 1 | Active-low synchronous reset |
| hostData | input | 8 | Host data bus |
| hostAddrLo | input | 13 | Host address lines A0-A12 |
| ioSelN | input | 1 | Active-low I/O-page select |
| phi2 | input | 1 | Bus phase, high during CPU-owned cycles |
| rwN | input | 1 | Host read/write, low for a write |
| romLowN | input | 1 | Active-low low-ROM window strobe |
| romHighN | input | 1 | Active-low high-ROM window strobe |
| romAddr | output | ROM_AW | ROM address: window offset plus bank bits |
| romEnN | output | 1 | Active-low ROM chip and output enable |

## Verification
Bank writes are tried with bit 7 set and with high bits set beyond the kept width, which separates a correct mask from a full-byte capture. Writes with exactly one of the three qualifiers wrong show whether each qualifier gates the load on its own. A write held over several clocks shows that the outputs stay steady. A long seeded random mix of all the control lines, run against a bench model, covers combinations the directed cases miss, and it is applied to both the plain build and the 16 KiB-pair build.

// File: rtl/cart_bank_pkg.sv
package cart_bank_pkg;

  typedef struct packed {
    logic loadBank;   // qualified host write this cycle
    logic romSelect;  // either window strobe active
    logic highHalf;   // low-ROM strobe inactive
  } bankStrobes_t;

  function automatic int romAddrBits(input int romKb);
    return $clog2(romKb * 1024);
  endfunction

endpackage

// File: rtl/bank_select_ctrl.sv
module bank_select_ctrl
  import cart_bank_pkg::*;
(
  input  logic         ioSelN,
  input  logic         phi2,
  input  logic         rwN,
  input  logic         romLowN,
  input  logic         romHighN,
  output bankStrobes_t strb
);

  always_comb begin
    strb.loadBank  = ~ioSelN & phi2 & ~rwN;
    strb.romSelect = ~(romLowN & romHighN);
    strb.highHalf  = romLowN;
  end

endmodule

// File: rtl/bank_addr_path.sv
module bank_addr_path
  import cart_bank_pkg::*;
#(
  parameter int BANK_W     = 4,
  parameter int WINDOW_A13 = 0,
  parameter int ROM_AW     = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  bankStrobes_t      strb,
  input  logic [7:0]        dataIn,
  input  logic [12:0]       hostAddrLo,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romEnN
);

  logic [BANK_W-1:0] bankReg;

  always_ff @(posedge clk) begin
    if (!rstN)              bankReg <= '0;
    else if (strb.loadBank) bankReg <= dataIn[BANK_W-1:0];
  end

  generate
    if (WINDOW_A13 != 0) begin : g_pairWindow
      assign romAddr = {bankReg, strb.highHalf, hostAddrLo};
    end else begin : g_plainWindow
      assign romAddr = {bankReg, hostAddrLo};
    end
  endgenerate

  assign romEnN = ~strb.romSelect;

  // R3: register moves only after a qualified write
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadBank |=> $stable(bankReg));

  // R2: a qualified write captures the low data bits
  p_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadBank |=> bankReg == $past(dataIn[BANK_W-1:0]));

  // R5: high data bits never leak into the bank
  p_upper_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.loadBank && dataIn[7]) |=> bankReg == $past(dataIn[BANK_W-1:0]));

  // R1: bank is zero right after reset
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> bankReg == '0);

endmodule

// File: rtl/cart_bank_latch.sv
module cart_bank_latch
  import cart_bank_pkg::*;
#(
  parameter int ROM_KB     = 128,
  parameter int WINDOW_A13 = 0,
  parameter int ROM_AW     = romAddrBits(ROM_KB)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        hostData,
  input  logic [12:0]       hostAddrLo,
  input  logic              ioSelN,
  input  logic              phi2,
  input  logic              rwN,
  input  logic              romLowN,
  input  logic              romHighN,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romEnN
);

  localparam int BANK_W = ROM_AW - 13 - WINDOW_A13;

  bankStrobes_t strb;

  bank_select_ctrl u_ctrl (
    .ioSelN   (ioSelN),
    .phi2     (phi2),
    .rwN      (rwN),
    .romLowN  (romLowN),
    .romHighN (romHighN),
    .strb     (strb)
  );

  bank_addr_path #(
    .BANK_W     (BANK_W),
    .WINDOW_A13 (WINDOW_A13),
    .ROM_AW     (ROM_AW)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .dataIn     (hostData),
    .hostAddrLo (hostAddrLo),
    .romAddr    (romAddr),
    .romEnN     (romEnN)
  );

  // R4: a read cycle never alters the bank lines
  p_read_keeps_bank_r4: assert property (@(posedge clk) disable iff (!rstN)
    rwN |=> $stable(romAddr[ROM_AW-1:ROM_AW-BANK_W]));

  // R3: no Phi2 means no bank change
  p_phi2_low_keeps_r3: assert property (@(posedge clk) disable iff (!rstN)
    !phi2 |=> $stable(romAddr[ROM_AW-1:ROM_AW-BANK_W]));

  // R6: low address passes through
  p_addr_pass_r6: assert property (@(posedge clk) disable iff (!rstN)
    romAddr[12:0] == hostAddrLo);

  // R7: ROM enabled only inside a window
  p_enable_window_r7: assert property (@(posedge clk) disable iff (!rstN)
    (romLowN && romHighN) |-> romEnN);

endmodule

// File: tb/cart_bank_latch_bench.sv
module cart_bank_latch_bench;

  localparam int CLK_HALF = 10;  // 50 MHz

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  hostData = '0;
  logic [12:0] hostAddrLo = '0;
  logic        ioSelN = 1'b1;
  logic        phi2 = 1'b0;
  logic        rwN = 1'b1;
  logic        romLowN = 1'b1;
  logic        romHighN = 1'b1;
  logic [16:0] romAddr;
  logic        romEnN;
  logic [17:0] romAddrW;
  logic        romEnNW;

  int testCount = 0;
  int failCount = 0;
  bit finished = 0;
  logic [3:0] expBank = '0;

  always #CLK_HALF clk = ~clk;

  cart_bank_latch u_cart_bank_latch (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostAddrLo(hostAddrLo),
    .ioSelN(ioSelN), .phi2(phi2), .rwN(rwN), .romLowN(romLowN),
    .romHighN(romHighN), .romAddr(romAddr), .romEnN(romEnN)
  );

  cart_bank_latch #(.ROM_KB(256), .WINDOW_A13(1)) u_cart_bank_latch_win (
    .clk(clk), .rstN(rstN), .hostData(hostData), .hostAddrLo(hostAddrLo),
    .ioSelN(ioSelN), .phi2(phi2), .rwN(rwN), .romLowN(romLowN),
    .romHighN(romHighN), .romAddr(romAddrW), .romEnN(romEnNW)
  );

  function automatic logic [16:0] expPlain(logic [3:0] b, logic [12:0] a);
    return {b, a};
  endfunction

  function automatic logic [17:0] expPair(logic [3:0] b, logic l, logic [12:0] a);
    return {b, l, a};
  endfunction

  function automatic bit qualifies(logic s, logic p, logic r);
    return !s && p && !r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check({tag, " plain addr"}, 32'(romAddr), 32'(expPlain(expBank, hostAddrLo)));
    check({tag, " pair addr R8"}, 32'(romAddrW), 32'(expPair(expBank, romLowN, hostAddrLo)));
    check({tag, " enable R7"}, 32'(romEnN), 32'(romLowN & romHighN));
  endtask

  // one bus cycle: drive at negedge, model update at posedge, check after
  task automatic busCycle(input logic s, input logic p, input logic r, input logic [7:0] d);
    @(negedge clk);
    ioSelN = s; phi2 = p; rwN = r; hostData = d;
    @(posedge clk);
    if (rstN && qualifies(s, p, r)) expBank = d[3:0];
    @(negedge clk);
    ioSelN = 1'b1; phi2 = 1'b0; rwN = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_c0de));
    // R1: qualifying write held during reset is overridden
    ioSelN = 1'b0; phi2 = 1'b1; rwN = 1'b0; hostData = 8'h0F;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 bank in reset", 32'(romAddr[16:13]), 32'h0);
    ioSelN = 1'b1; phi2 = 1'b0; rwN = 1'b1;
    rstN = 1'b1;
    @(negedge clk);
    check("R1 bank after reset", 32'(romAddr[16:13]), 32'h0);

    // R6, R7 combinational paths
    hostAddrLo = 13'h1ABC; romLowN = 1'b0; romHighN = 1'b1;
    #1;
    check("R6 addr pass", 32'(romAddr[12:0]), 32'h1ABC);
    check("R7 enable low window", 32'(romEnN), 32'h0);
    check("R8 pair A13 low half", 32'(romAddrW[13]), 32'h0);
    romLowN = 1'b1; romHighN = 1'b1;
    #1;
    check("R7 enable idle", 32'(romEnN), 32'h1);
    check("R8 pair A13 high half", 32'(romAddrW[13]), 32'h1);
    romHighN = 1'b0;
    #1;
    check("R7 enable high window", 32'(romEnN), 32'h0);

    // R2, R5: load with bit 7 set
    busCycle(1'b0, 1'b1, 1'b0, 8'h85);
    check("R2 R5 load 0x85", 32'(romAddr[16:13]), 32'h5);
    check("R2 D0 on A13", 32'(romAddr[13]), 32'h1);
    checkAll("R2");
    busCycle(1'b0, 1'b1, 1'b0, 8'hFA);
    check("R5 upper bits dropped", 32'(romAddr[16:13]), 32'hA);
    check("R5 pair upper dropped", 32'(romAddrW[17:14]), 32'hA);

    // R3, R4: disqualified cycles
    busCycle(1'b0, 1'b0, 1'b0, 8'h03);
    check("R3 phi2 low", 32'(romAddr[16:13]), 32'hA);
    busCycle(1'b1, 1'b1, 1'b0, 8'h03);
    check("R3 io select high", 32'(romAddr[16:13]), 32'hA);
    busCycle(1'b0, 1'b1, 1'b1, 8'h03);
    check("R4 read cycle", 32'(romAddr[16:13]), 32'hA);

    // R9: held write
    @(negedge clk);
    ioSelN = 1'b0; phi2 = 1'b1; rwN = 1'b0; hostData = 8'h07;
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      expBank = 4'h7;
      #3;
      check("R9 held write", 32'(romAddr[16:13]), 32'h7);
      @(negedge clk);
      check("R9 held stable", 32'(romAddr[16:13]), 32'h7);
    end
    ioSelN = 1'b1; phi2 = 1'b0; rwN = 1'b1;

    // random mix covering R2-R8
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      ioSelN = 1'($urandom % 2); phi2 = 1'($urandom % 2); rwN = 1'($urandom % 2);
      hostData = 8'($urandom); hostAddrLo = 13'($urandom);
      romLowN = 1'($urandom % 2); romHighN = 1'($urandom % 2);
      #1;
      checkAll("random R2 R3 R4 R6");
      @(posedge clk);
      if (qualifies(ioSelN, phi2, rwN)) expBank = hostData[3:0];
    end
    @(negedge clk);
    checkAll("random final R5");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog R1-scope run actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

endmodule